// File: doc/BRIEF.md
# AES-128 Block Encryption Accelerator

This block encrypts one 128-bit block each time software issues a start command. Software loads a 128-bit key, a 128-bit counter block and a 128-bit text block one byte at a time through a small register port. It then picks one of four modes and sets a start bit. The bit clears itself. An iterative AES-128 engine runs one round per clock. The block reports busy and done status, and the result can then be read back one byte at a time. Decryption and other key sizes are not supported.

Four modes are available:
- **Plain mode** returns the cipher of the text.
- **Counter mode** XORs the text with the cipher of the counter block.
- **Chained mode** encrypts the text XORed with a stored chaining value, and the result becomes the new chaining value. A control bit zeroes the chaining value.
- **Combined mode** runs the chained pass first, to update an authentication value. It then runs the counter pass to produce the ciphertext, so it takes two engine passes.

The key stays in place between operations. The block stays locked after reset. It ignores every start command until a software-triggered self test has passed. The self test encrypts a fixed known-answer vector and compares the output.

Top module: `aes_acc`

## Requirements
- R1: After reset, every key, counter, text, result and chaining byte reads 0, and the status byte reads 0.
- R2: The register port uses `addr[6:4]` to select a region and `addr[3:0]` to select a byte within it. The regions are:
  - 0: key
  - 1: counter
  - 2: text
  - 3: result (read-only)
  - 4: chaining value (read-only)
  - 5: control/status

  Byte offset 0 is the first byte of the AES block, which is the most significant byte. Key, counter and text bytes read back as written. Unmapped regions read 0.
- R3: A control write takes these fields:
  - bit 0: start
  - bit 1: self test
  - bit 2: clear chain
  - bits 7:6: mode

  The status byte reads as follows:
  - bits 1:0: always 0, so start and self test read back as 0
  - bit 2: busy
  - bit 3: done
  - bit 4: self-test pass
  - bit 5: self-test fail
  - bits 7:6: mode

  An accepted start raises busy on the edge of the write. Busy then stays high for exactly 10 further cycles, which is 11 edges in all. It stays high for 20 cycles in combined mode. Done is set when busy falls.
- R4: Mode 0 (plain): result = AES(key, text).
- R5: Mode 1 (counter): result = text XOR AES(key, counter).
- R6: Mode 2 (chained): result = AES(key, text XOR chain), and chain then takes the result. Writing the clear-chain bit zeroes the chain before any start in the same write.
- R7: Mode 3 (combined): chain takes AES(key, text XOR chain), then result = text XOR AES(key, counter).
- R8: The key is retained across operations, so a new block needs only new text and counter bytes.
- R9: While busy, the block ignores writes to key, counter and text, and control writes of any kind. This includes mode changes and a second start.
- R10: Before a self test has passed, a start command does not raise busy. The self-test bit encrypts the known-answer vector below in 10 cycles and sets exactly one of pass and fail:
  - key: 000102...0f
  - plaintext: 00112233...ff
  - expected ciphertext: 69c4e0d86a7b0430d8cdb78070b4c55a

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Byte write strobe |
| addr | input | 7 | Byte address (region and byte index) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |

## Verification
The hardest case to reach from the ports is a register write arriving in the middle of a running operation. The write must change neither the block under encryption nor the key, nor restart the engine. The bench launches a plain encryption and, without waiting, issues writes to text, key and control, including a mode change with a second start. These writes all land inside the 10-cycle busy window. The bench then checks the result, the read-back bytes, the mode field and the cycle count. The chained and combined modes are driven as multi-block sequences, so the chaining state carried between blocks is exercised as well.

// File: rtl/aes_acc_pkg.sv
package aes_acc_pkg;

    localparam int BLK_BITS  = 128;
    localparam int BLK_BYTES = BLK_BITS / 8;
    localparam int ROUNDS    = 10;

    typedef enum logic [1:0] {
        MODE_PLAIN = 2'd0,
        MODE_CTR   = 2'd1,
        MODE_CHAIN = 2'd2,
        MODE_BOTH  = 2'd3
    } mode_e;

    localparam logic [2:0] RG_KEY = 3'd0;
    localparam logic [2:0] RG_CTR = 3'd1;
    localparam logic [2:0] RG_TXT = 3'd2;
    localparam logic [2:0] RG_RES = 3'd3;
    localparam logic [2:0] RG_CHN = 3'd4;
    localparam logic [2:0] RG_CTL = 3'd5;

    localparam logic [127:0] KAT_KEY = 128'h000102030405060708090a0b0c0d0e0f;
    localparam logic [127:0] KAT_PT  = 128'h00112233445566778899aabbccddeeff;
    localparam logic [127:0] KAT_CT  = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;

    function automatic logic [7:0] xt(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p;
        logic [7:0] x;
        p = 8'h00;
        x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p = p ^ x;
            x = xt(x);
        end
        return p;
    endfunction

    function automatic logic [7:0] rotl8(input logic [7:0] b, input int k);
        return 8'((b << k) | (b >> (8 - k)));
    endfunction

    // multiplicative inverse as x^254, then the affine map
    function automatic logic [7:0] sbox(input logic [7:0] x);
        logic [7:0] r;
        logic [7:0] base;
        r    = 8'h01;
        base = x;
        for (int i = 0; i < 8; i++) begin
            if (i != 0) r = gf_mul(r, base);
            base = gf_mul(base, base);
        end
        return r ^ rotl8(r, 1) ^ rotl8(r, 2) ^ rotl8(r, 3) ^ rotl8(r, 4) ^ 8'h63;
    endfunction

    function automatic logic [7:0] rcon(input logic [3:0] rnd);
        logic [7:0] v;
        v = 8'h01;
        for (int i = 1; i < ROUNDS; i++) begin
            if (i < int'(rnd)) v = xt(v);
        end
        return v;
    endfunction

endpackage

// File: rtl/aes_acc_round.sv
module aes_acc_round
    import aes_acc_pkg::*;
(
    input  logic [BLK_BITS-1:0] st_i,
    input  logic [BLK_BITS-1:0] rk_i,
    input  logic                last_i,
    output logic [BLK_BITS-1:0] st_o
);
    logic [7:0] sb [BLK_BYTES];
    logic [7:0] sr [BLK_BYTES];
    logic [7:0] mc [BLK_BYTES];

    for (genvar i = 0; i < BLK_BYTES; i++) begin : g_sub
        assign sb[i] = sbox(st_i[BLK_BITS-1-8*i -: 8]);
    end

    for (genvar c = 0; c < 4; c++) begin : g_col
        for (genvar r = 0; r < 4; r++) begin : g_row
            assign sr[c*4+r] = sb[((c+r)%4)*4+r];
            assign mc[c*4+r] = xt(sr[c*4+r]) ^ xt(sr[c*4+(r+1)%4]) ^ sr[c*4+(r+1)%4]
                             ^ sr[c*4+(r+2)%4] ^ sr[c*4+(r+3)%4];
            assign st_o[BLK_BITS-1-8*(c*4+r) -: 8] =
                (last_i ? sr[c*4+r] : mc[c*4+r]) ^ rk_i[BLK_BITS-1-8*(c*4+r) -: 8];
        end
    end
endmodule

// File: rtl/aes_acc_keystep.sv
module aes_acc_keystep
    import aes_acc_pkg::*;
(
    input  logic [BLK_BITS-1:0] rk_i,
    input  logic [7:0]          rcon_i,
    output logic [BLK_BITS-1:0] rk_o
);
    logic [31:0] w [4];
    logic [31:0] n [4];
    logic [31:0] rot;
    logic [31:0] tmp;

    for (genvar i = 0; i < 4; i++) begin : g_w
        assign w[i] = rk_i[BLK_BITS-1-32*i -: 32];
        assign rk_o[BLK_BITS-1-32*i -: 32] = n[i];
    end

    assign rot = {w[3][23:0], w[3][31:24]};
    assign tmp = {sbox(rot[31:24]) ^ rcon_i, sbox(rot[23:16]), sbox(rot[15:8]), sbox(rot[7:0])};

    assign n[0] = w[0] ^ tmp;
    for (genvar i = 1; i < 4; i++) begin : g_n
        assign n[i] = w[i] ^ n[i-1];
    end
endmodule

// File: rtl/aes_acc.sv
module aes_acc
    import aes_acc_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);
    localparam int IDX_W = $clog2(BLK_BYTES);
    localparam int RG_W  = ADDR_W - IDX_W;

    typedef struct packed {
        logic [BLK_BITS-1:0] key;
        logic [BLK_BITS-1:0] ctr;
        logic [BLK_BITS-1:0] txt;
        logic [BLK_BITS-1:0] res;
        logic [BLK_BITS-1:0] chn;
        logic [BLK_BITS-1:0] st;
        logic [BLK_BITS-1:0] rk;
        logic [3:0]          rnd;
        logic                busy;
        logic                done;
        logic                pass;
        logic                fail;
        logic                selftest;
        logic                phase;
        mode_e               mode;
    } regs_t;

    regs_t r_d, r_q;

    logic [RG_W-1:0]     rg;
    logic [IDX_W-1:0]    idx;
    int                  bpos;
    logic [BLK_BITS-1:0] rk_nx;
    logic [BLK_BITS-1:0] rnd_out;
    logic                ctl_unused;
    logic [BLK_BITS-1:0] blk_in;
    logic [BLK_BITS-1:0] key_use;

    assign rg         = addr[ADDR_W-1:IDX_W];
    assign idx        = addr[IDX_W-1:0];
    assign bpos       = BLK_BITS - 1 - 8 * int'(idx);
    assign ctl_unused = ^wdata[5:3];

    aes_acc_keystep u_key (
        .rk_i   (r_q.rk),
        .rcon_i (rcon(r_q.rnd)),
        .rk_o   (rk_nx)
    );

    aes_acc_round u_round (
        .st_i   (r_q.st),
        .rk_i   (rk_nx),
        .last_i (r_q.rnd == 4'(ROUNDS)),
        .st_o   (rnd_out)
    );

    always_comb begin
        r_d     = r_q;
        blk_in  = '0;
        key_use = '0;
        if (!r_q.busy) begin
            if (wr_en) begin
                case (rg)
                    RG_W'(RG_KEY): r_d.key[bpos -: 8] = wdata;
                    RG_W'(RG_CTR): r_d.ctr[bpos -: 8] = wdata;
                    RG_W'(RG_TXT): r_d.txt[bpos -: 8] = wdata;
                    RG_W'(RG_CTL): begin
                        r_d.mode = mode_e'(wdata[7:6]);
                        if (wdata[2]) r_d.chn = '0;
                        if (wdata[1] || (wdata[0] && r_q.pass)) begin
                            r_d.selftest = wdata[1];
                            r_d.busy     = 1'b1;
                            r_d.done     = 1'b0;
                            r_d.phase    = 1'b0;
                            r_d.rnd      = 4'd1;
                            key_use      = wdata[1] ? KAT_KEY : r_q.key;
                            if (wdata[1])                                          blk_in = KAT_PT;
                            else if (r_d.mode == MODE_CHAIN || r_d.mode == MODE_BOTH) blk_in = r_q.txt ^ r_d.chn;
                            else if (r_d.mode == MODE_CTR)                         blk_in = r_q.ctr;
                            else                                                   blk_in = r_q.txt;
                            r_d.st = blk_in ^ key_use;
                            r_d.rk = key_use;
                        end
                    end
                    default: ;
                endcase
            end
        end else begin
            r_d.st  = rnd_out;
            r_d.rk  = rk_nx;
            r_d.rnd = r_q.rnd + 4'd1;
            if (r_q.rnd == 4'(ROUNDS)) begin
                r_d.busy = 1'b0;
                r_d.done = 1'b1;
                if (r_q.selftest) begin
                    r_d.pass     = (rnd_out == KAT_CT);
                    r_d.fail     = (rnd_out != KAT_CT);
                    r_d.selftest = 1'b0;
                end else begin
                    case (r_q.mode)
                        MODE_PLAIN: r_d.res = rnd_out;
                        MODE_CTR:   r_d.res = r_q.txt ^ rnd_out;
                        MODE_CHAIN: begin
                            r_d.res = rnd_out;
                            r_d.chn = rnd_out;
                        end
                        default: begin
                            if (!r_q.phase) begin
                                r_d.chn   = rnd_out;
                                r_d.phase = 1'b1;
                                r_d.busy  = 1'b1;
                                r_d.done  = 1'b0;
                                r_d.rnd   = 4'd1;
                                r_d.st    = r_q.ctr ^ r_q.key;
                                r_d.rk    = r_q.key;
                            end else begin
                                r_d.res = r_q.txt ^ rnd_out;
                            end
                        end
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (rg)
            RG_W'(RG_KEY): rdata = r_q.key[bpos -: 8];
            RG_W'(RG_CTR): rdata = r_q.ctr[bpos -: 8];
            RG_W'(RG_TXT): rdata = r_q.txt[bpos -: 8];
            RG_W'(RG_RES): rdata = r_q.res[bpos -: 8];
            RG_W'(RG_CHN): rdata = r_q.chn[bpos -: 8];
            RG_W'(RG_CTL): rdata = {r_q.mode, r_q.fail, r_q.pass, r_q.done, r_q.busy, 2'b00};
            default:       rdata = 8'h00;
        endcase
    end

    logic                busy_w, done_w, pass_w, fail_w;
    logic [BLK_BITS-1:0] key_w;
    assign busy_w = r_q.busy;
    assign done_w = r_q.done;
    assign pass_w = r_q.pass;
    assign fail_w = r_q.fail;
    assign key_w  = r_q.key;

endmodule

// File: rtl/aes_acc_sva.sv
module aes_acc_sva
    import aes_acc_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [1:0]          wdata_lo,
    input logic                busy,
    input logic                done,
    input logic                pass,
    input logic                fail,
    input logic [BLK_BITS-1:0] key
);
    logic [4:0] run_q;
    logic       start_wr;

    assign start_wr = wr_en && (addr[ADDR_W-1:4] == (ADDR_W-4)'(RG_CTL)) && wdata_lo == 2'b01;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 5'd1;
        else           run_q <= '0;
    end

    assert_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr && !pass && !busy) |=> !busy);

    assert_busy_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == 5'd10 || run_q == 5'd20));

    assert_done_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_key_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(key));

    assert_pass_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass && fail));
endmodule

bind aes_acc aes_acc_sva #(.ADDR_W(ADDR_W)) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata_lo (wdata[1:0]),
    .busy     (busy_w),
    .done     (done_w),
    .pass     (pass_w),
    .fail     (fail_w),
    .key      (key_w)
);

// File: tb/aes_acc_bench.sv
`timescale 1ns/1ps
module aes_acc_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [6:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [7:0] sb_tab [256];

    localparam logic [6:0] A_KEY = 7'h00, A_CTR = 7'h10, A_TXT = 7'h20,
                           A_RES = 7'h30, A_CHN = 7'h40, A_CTL = 7'h50;

    always #2.5 clk = ~clk;

    aes_acc u_aes_acc (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata));

    function automatic logic [7:0] dbl(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] rl(input logic [7:0] a, input int k);
        return 8'((a << k) | (a >> (8 - k)));
    endfunction

    function automatic logic [127:0] ref_aes(input logic [127:0] k, input logic [127:0] p);
        logic [31:0] w [44];
        logic [7:0]  s [16];
        logic [7:0]  t [16];
        logic [31:0] tmp;
        logic [7:0]  rc;
        logic [127:0] o;
        rc = 8'h01;
        for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
        for (int i = 4; i < 44; i++) begin
            tmp = w[i-1];
            if (i % 4 == 0) begin
                tmp = {sb_tab[tmp[23:16]] ^ rc, sb_tab[tmp[15:8]], sb_tab[tmp[7:0]], sb_tab[tmp[31:24]]};
                rc = dbl(rc);
            end
            w[i] = w[i-4] ^ tmp;
        end
        for (int i = 0; i < 16; i++) s[i] = p[127-8*i -: 8] ^ w[i/4][31-8*(i%4) -: 8];
        for (int r = 1; r <= 10; r++) begin
            for (int i = 0; i < 16; i++) t[i] = sb_tab[s[i]];
            for (int c = 0; c < 4; c++)
                for (int q = 0; q < 4; q++) s[c*4+q] = t[((c+q)%4)*4+q];
            if (r < 10) begin
                for (int c = 0; c < 4; c++) begin
                    logic [7:0] a0, a1, a2, a3;
                    a0 = s[c*4]; a1 = s[c*4+1]; a2 = s[c*4+2]; a3 = s[c*4+3];
                    s[c*4]   = dbl(a0) ^ dbl(a1) ^ a1 ^ a2 ^ a3;
                    s[c*4+1] = a0 ^ dbl(a1) ^ dbl(a2) ^ a2 ^ a3;
                    s[c*4+2] = a0 ^ a1 ^ dbl(a2) ^ dbl(a3) ^ a3;
                    s[c*4+3] = dbl(a0) ^ a0 ^ a1 ^ a2 ^ dbl(a3);
                end
            end
            for (int i = 0; i < 16; i++) s[i] = s[i] ^ w[4*r + i/4][31-8*(i%4) -: 8];
        end
        for (int i = 0; i < 16; i++) o[127-8*i -: 8] = s[i];
        return o;
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic load_blk(input logic [6:0] base, input logic [127:0] v);
        for (int i = 0; i < 16; i++) wr(base + 7'(i), v[127-8*i -: 8]);
    endtask

    task automatic read_blk(input logic [6:0] base, output logic [127:0] v);
        for (int i = 0; i < 16; i++) begin
            logic [7:0] b;
            rd(base + 7'(i), b);
            v[127-8*i -: 8] = b;
        end
    endtask

    task automatic wait_idle(output int n);
        logic [7:0] s;
        n = 0;
        addr = A_CTL;
        #1 s = rdata;
        while (s[2] && n < 100) begin
            n++;
            @(negedge clk);
            addr = A_CTL;
            #1 s = rdata;
        end
    endtask

    task automatic run_cmd(input logic [7:0] ctl, output int n);
        wr(A_CTL, ctl);
        wait_idle(n);
    endtask

    initial begin
        logic [7:0] p, q, x;
        p = 8'h01; q = 8'h01;
        sb_tab[0] = 8'h63;
        do begin
            p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1b : 8'h00);
            q = q ^ {q[6:0], 1'b0};
            q = q ^ {q[5:0], 2'b00};
            q = q ^ {q[3:0], 4'b0000};
            if (q[7]) q = q ^ 8'h09;
            x = q ^ rl(q, 1) ^ rl(q, 2) ^ rl(q, 3) ^ rl(q, 4);
            sb_tab[p] = x ^ 8'h63;
        end while (p != 8'h01);
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R3 watchdog act=hung exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [127:0] k, t, c, v, chn, res, exp;
        logic [7:0]   s;
        int           n;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(A_CTL, s);
        chk(s == 8'h00, "R1 status", 128'(s), 0);
        read_blk(A_RES, v);
        chk(v == 0, "R1 result", v, 0);
        read_blk(A_KEY, v);
        chk(v == 0, "R1 key", v, 0);

        // sanity of bench model on known answer
        chk(ref_aes(128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff)
            == 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R10 model", 0, 0);

        // R2: load and read back, unmapped region
        k = rnd128(); t = rnd128();
        load_blk(A_KEY, k);
        load_blk(A_TXT, t);
        read_blk(A_KEY, v);
        chk(v == k, "R2 key readback", v, k);
        read_blk(A_TXT, v);
        chk(v == t, "R2 text readback", v, t);
        rd(7'h70, s);
        chk(s == 8'h00, "R2 unmapped", 128'(s), 0);

        // R10: locked before self test
        run_cmd(8'h01, n);
        chk(n == 0, "R10 start locked", 128'(n), 0);
        read_blk(A_RES, v);
        chk(v == 0, "R10 no result while locked", v, 0);

        // R10 / R3: self test
        run_cmd(8'h02, n);
        chk(n == 10, "R3 selftest cycles", 128'(n), 10);
        rd(A_CTL, s);
        chk(s[5:4] == 2'b01, "R10 pass flag", 128'(s), 128'h10);
        chk(s[1:0] == 2'b00 && s[3], "R3 start self-clear and done", 128'(s), 128'h18);

        // R4: plain mode, random patterns
        for (int i = 0; i < 4; i++) begin
            k = rnd128(); t = rnd128();
            load_blk(A_KEY, k);
            load_blk(A_TXT, t);
            run_cmd(8'h01, n);
            chk(n == 10, "R3 plain cycles", 128'(n), 10);
            read_blk(A_RES, v);
            exp = ref_aes(k, t);
            chk(v == exp, "R4 plain result", v, exp);
        end

        // R8: key retained, only text rewritten
        t = rnd128();
        load_blk(A_TXT, t);
        run_cmd(8'h01, n);
        read_blk(A_RES, v);
        exp = ref_aes(k, t);
        chk(v == exp, "R8 key retained", v, exp);

        // R5: counter mode
        for (int i = 0; i < 3; i++) begin
            c = rnd128(); t = rnd128();
            if (i == 2) c = {128{1'b1}};
            load_blk(A_CTR, c);
            load_blk(A_TXT, t);
            run_cmd(8'h41, n);
            read_blk(A_RES, v);
            exp = t ^ ref_aes(k, c);
            chk(v == exp, "R5 counter result", v, exp);
        end
        rd(A_CTL, s);
        chk(s[7:6] == 2'b01, "R3 mode field", 128'(s[7:6]), 1);

        // R6: chained mode, three blocks from zeroed chain
        wr(A_CTL, 8'h84);
        read_blk(A_CHN, v);
        chk(v == 0, "R6 clear chain", v, 0);
        chn = '0;
        for (int i = 0; i < 3; i++) begin
            t = rnd128();
            load_blk(A_TXT, t);
            run_cmd(8'h81, n);
            chn = ref_aes(k, t ^ chn);
            read_blk(A_RES, v);
            chk(v == chn, "R6 chain result", v, chn);
            read_blk(A_CHN, v);
            chk(v == chn, "R6 chain state", v, chn);
        end
        t = rnd128();
        load_blk(A_TXT, t);
        run_cmd(8'h85, n);
        read_blk(A_RES, v);
        exp = ref_aes(k, t);
        chk(v == exp, "R6 clear with start", v, exp);

        // R7: combined mode, two blocks
        wr(A_CTL, 8'hC4);
        chn = '0;
        for (int i = 0; i < 2; i++) begin
            t = rnd128(); c = rnd128();
            load_blk(A_TXT, t);
            load_blk(A_CTR, c);
            run_cmd(8'hC1, n);
            chk(n == 20, "R3 combined cycles", 128'(n), 20);
            chn = ref_aes(k, t ^ chn);
            exp = t ^ ref_aes(k, c);
            read_blk(A_RES, res);
            chk(res == exp, "R7 combined result", res, exp);
            read_blk(A_CHN, v);
            chk(v == chn, "R7 combined mac", v, chn);
        end

        // R9: writes while busy are ignored
        t = rnd128();
        load_blk(A_TXT, t);
        wr(A_CTL, 8'h01);
        wr(A_TXT, ~t[127:120]);
        wr(A_KEY + 7'd3, ~k[103:96]);
        wr(A_CTL, 8'h47);
        wait_idle(n);
        chk(n <= 10, "R9 no restart", 128'(n), 10);
        repeat (3) @(negedge clk);
        rd(A_CTL, s);
        chk(s[2] == 1'b0 && s[7:6] == 2'b00, "R9 mode and busy unchanged", 128'(s), 128'h18);
        read_blk(A_RES, v);
        exp = ref_aes(k, t);
        chk(v == exp, "R9 result unaffected", v, exp);
        read_blk(A_TXT, v);
        chk(v == t, "R9 text unchanged", v, t);
        read_blk(A_KEY, v);
        chk(v == k, "R9 key unchanged", v, k);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule